// File: doc/BRIEF.md
# Fence-Aware Micro-Op Issue Controller

This block sits between a decoded micro-op queue and the out-of-order core. Each clock it looks at up to `W` ops at the queue head, in program order. It picks the longest prefix that may enter the machine this cycle, and allocates each picked op a reorder buffer (ROB) entry. In the same cycle, it also allocates a scheduler entry to each picked op that needs an execution port. Ops that need no port (nops, zeroing idioms, fences) bypass the scheduler and enter the ROB already marked complete. The queue pops exactly the slots flagged on `rob_alloc_o`.

A load-fence op is allocated as soon as it reaches issue, even if older ops are still in flight. Issue then stops for everything after it. It restarts one cycle after the ROB is seen to be empty, which means every op older than the fence and the fence itself have retired. Issue also narrows or stops whenever the scheduler or the ROB reports too few free entries.

Top module: `fence_aware_issue`

## Requirements
- R1: Coming out of reset, the block is not waiting on a fence. In the first cycle after reset release, ops issue normally, even if a fence wait was pending before reset.
- R2: With no fence wait and enough free entries, every slot of the longest run of valid slots starting at slot 0 issues, up to `W` per cycle.
- R3: Issue is in order. If slot k does not issue, no slot above k issues that cycle. An invalid slot stops issue at that slot.
- R4: Every issued op has its `rob_alloc_o` bit set in the cycle it issues. A `sched_alloc_o` bit is never set without the matching `rob_alloc_o` bit.
- R5: An issued op sets its `sched_alloc_o` bit exactly when both `op_noexec_i` and `op_fence_i` are 0 for that slot.
- R6: The number of `sched_alloc_o` bits never exceeds `sched_free_i`. An op that needs a port and finds the scheduler full stops issue at its slot. An op that needs no port may still issue while the scheduler is full.
- R7: The number of `rob_alloc_o` bits never exceeds `rob_free_i`.
- R8: A fence issues even when the ROB is not empty. Slots above an issued fence do not issue in the same cycle.
- R9: In every cycle after a fence issues, no op issues until `rob_empty_i` has been sampled high at a clock edge. The value of `rob_empty_i` in the fence's own issue cycle is ignored.
- R10: Issue resumes in the cycle after the edge at which `rob_empty_i` is sampled high, not in the same cycle.
- R11: `rob_done_o` flags, among the issued slots, exactly those that need no port. These ops enter the ROB already complete, and `rob_done_o` is never set together with `sched_alloc_o` on a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | W | Slot holds a decoded op (bit 0 is the oldest) |
| op_noexec_i | input | W | Op needs no execution port |
| op_fence_i | input | W | Op is a load fence (needs no port) |
| sched_free_i | input | CNT_W | Free scheduler entries |
| rob_free_i | input | CNT_W | Free ROB entries |
| rob_empty_i | input | 1 | ROB holds no op |
| sched_alloc_o | output | W | Slot allocates a scheduler entry |
| rob_alloc_o | output | W | Slot allocates a ROB entry and is popped from the queue |
| rob_done_o | output | W | Slot's ROB entry is written as already executed |

## Verification
The only internal state is the fence-wait flag. A flag that sets wrongly shows up in the very next cycle as an all-zero allocation while the queue is valid and both structures have room. A flag that clears early shows up as allocations in the cycle `rob_empty_i` first rises, or while it is still low. A fault in the slot chain shows up in the same cycle as a non-prefix mask, a count above a free figure, or a scheduler strobe on a no-port op. The bench therefore compares all three strobes against a model in every cycle.

// File: rtl/fai_pkg.sv
package fai_pkg;
  function automatic logic needs_port(input logic noexec, input logic fence);
    return !(noexec || fence);
  endfunction
endpackage

// File: rtl/fai_select.sv
module fai_select
  import fai_pkg::*;
#(
  parameter int W     = 4,
  parameter int CNT_W = 8
) (
  input  logic             block_i,
  input  logic [W-1:0]     valid_i,
  input  logic [W-1:0]     noexec_i,
  input  logic [W-1:0]     fence_i,
  input  logic [CNT_W-1:0] sched_free_i,
  input  logic [CNT_W-1:0] rob_free_i,
  output logic [W-1:0]     take_o,
  output logic [W-1:0]     port_o
);
  localparam int RW = $clog2(W + 1);
  localparam int MW = ((CNT_W > RW) ? CNT_W : RW) + 1;

  logic [MW-1:0] s_run [W+1];
  logic [MW-1:0] r_run [W+1];
  logic          go    [W+1];
  logic [MW-1:0] s_cap, r_cap;

  assign s_cap    = MW'(sched_free_i);
  assign r_cap    = MW'(rob_free_i);
  assign go[0]    = !block_i;
  assign s_run[0] = '0;
  assign r_run[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_slot
    logic np, fits;
    assign np        = needs_port(noexec_i[k], fence_i[k]);
    assign fits      = valid_i[k] && (r_run[k] < r_cap) && (!np || (s_run[k] < s_cap));
    assign take_o[k] = go[k] && fits;
    assign port_o[k] = np;
    // a taken fence ends the group
    assign go[k+1]    = take_o[k] && !fence_i[k];
    assign r_run[k+1] = r_run[k] + MW'(take_o[k]);
    assign s_run[k+1] = s_run[k] + MW'(take_o[k] && np);
  end
endmodule

// File: rtl/fai_fence_gate.sv
module fai_fence_gate #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] take_i,
  input  logic [W-1:0] fence_i,
  input  logic         rob_empty_i,
  output logic         block_o
);
  logic wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wait_q <= 1'b0;
    else if (wait_q) wait_q <= !rob_empty_i;
    else             wait_q <= |(take_i & fence_i);
  end

  assign block_o = wait_q;
endmodule

// File: rtl/fence_aware_issue.sv
module fence_aware_issue #(
  parameter int W     = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     op_valid_i,
  input  logic [W-1:0]     op_noexec_i,
  input  logic [W-1:0]     op_fence_i,
  input  logic [CNT_W-1:0] sched_free_i,
  input  logic [CNT_W-1:0] rob_free_i,
  input  logic             rob_empty_i,
  output logic [W-1:0]     sched_alloc_o,
  output logic [W-1:0]     rob_alloc_o,
  output logic [W-1:0]     rob_done_o
);
  logic         block;
  logic [W-1:0] take, port;

  fai_select #(.W(W), .CNT_W(CNT_W)) i_select (
    .block_i     (block),
    .valid_i     (op_valid_i),
    .noexec_i    (op_noexec_i),
    .fence_i     (op_fence_i),
    .sched_free_i(sched_free_i),
    .rob_free_i  (rob_free_i),
    .take_o      (take),
    .port_o      (port)
  );

  fai_fence_gate #(.W(W)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .fence_i    (op_fence_i),
    .rob_empty_i(rob_empty_i),
    .block_o    (block)
  );

  assign rob_alloc_o   = take;
  assign sched_alloc_o = take & port;
  assign rob_done_o    = take & ~port;
endmodule

// File: rtl/fence_aware_issue_chk.sv
module fence_aware_issue_chk #(
  parameter int W     = 4,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [W-1:0]     op_valid_i,
  input logic [W-1:0]     op_fence_i,
  input logic [CNT_W-1:0] sched_free_i,
  input logic [CNT_W-1:0] rob_free_i,
  input logic             rob_empty_i,
  input logic [W-1:0]     sched_alloc_o,
  input logic [W-1:0]     rob_alloc_o,
  input logic [W-1:0]     rob_done_o
);
  AST_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rob_alloc_o + W'(1)) & rob_alloc_o) == '0); // R3
  AST_VALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_alloc_o & ~op_valid_i) == '0); // R3
  AST_SCHED_IN_ROB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_alloc_o & ~rob_alloc_o) == '0); // R4
  AST_SCHED_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sched_alloc_o) <= int'(sched_free_i)); // R6
  AST_ROB_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rob_alloc_o) <= int'(rob_free_i)); // R7
  AST_ONE_FENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rob_alloc_o & op_fence_i)); // R8
  AST_FENCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rob_alloc_o & op_fence_i)) |=> (rob_alloc_o == '0)); // R9
  AST_NO_EARLY_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rob_alloc_o == '0) && !rob_empty_i && $past(|(rob_alloc_o & op_fence_i)))
      |=> (rob_alloc_o == '0)); // R10
  AST_DONE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rob_done_o & sched_alloc_o) == '0) && ((rob_done_o & ~rob_alloc_o) == '0)); // R11
endmodule

bind fence_aware_issue fence_aware_issue_chk #(.W(W), .CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_valid_i   (op_valid_i),
  .op_fence_i   (op_fence_i),
  .sched_free_i (sched_free_i),
  .rob_free_i   (rob_free_i),
  .rob_empty_i  (rob_empty_i),
  .sched_alloc_o(sched_alloc_o),
  .rob_alloc_o  (rob_alloc_o),
  .rob_done_o   (rob_done_o)
);

// File: tb/test_fence_aware_issue.sv
module test_fence_aware_issue;
  localparam int W = 4;
  localparam int CNT_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] op_valid_i = '0, op_noexec_i = '0, op_fence_i = '0;
  logic [CNT_W-1:0] sched_free_i = '0, rob_free_i = '0;
  logic rob_empty_i = 1'b0;
  logic [W-1:0] sched_alloc_o, rob_alloc_o, rob_done_o;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_wait = 0;

  always #10 clk_i = ~clk_i;

  fence_aware_issue #(.W(W), .CNT_W(CNT_W)) i_fence_aware_issue (.*);

  function automatic logic [W-1:0] model(input logic [W-1:0] v, input logic [W-1:0] ne,
                                         input logic [W-1:0] f, input int sf, input int rf,
                                         input bit blk);
    logic [W-1:0] m = '0;
    int used_s = 0, used_r = 0;
    if (blk) return '0;
    for (int k = 0; k < W; k++) begin
      bit port = !(ne[k] | f[k]);
      if (!v[k] || used_r + 1 > rf || (port && used_s + 1 > sf)) break;
      m[k] = 1'b1;
      used_r++;
      if (port) used_s++;
      if (f[k]) break;
    end
    return m;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive at negedge, compare mid-low phase, advance model at posedge
  task automatic step(input logic [W-1:0] v, input logic [W-1:0] ne, input logic [W-1:0] f,
                      input int sf, input int rf, input bit re, input string tag);
    logic [W-1:0] e, port;
    @(negedge clk_i);
    op_valid_i = v; op_noexec_i = ne; op_fence_i = f;
    sched_free_i = CNT_W'(sf); rob_free_i = CNT_W'(rf); rob_empty_i = re;
    #5;
    e = model(v, ne, f, sf, rf, m_wait);
    port = ~(ne | f);
    chk({tag, " R2 R3 R6 R7 rob_alloc"}, rob_alloc_o, e);
    chk({tag, " R4 R5 sched_alloc"}, sched_alloc_o, e & port);
    chk({tag, " R11 rob_done"}, rob_done_o, e & ~port);
    @(posedge clk_i);
    if (m_wait) m_wait = !re;
    else m_wait = |(e & f);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1: first cycle after reset issues
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R1 after reset");

    // R2 R3 R5 R6 R7 R11: sweep without fences
    for (int v = 0; v < 16; v++)
      for (int ne = 0; ne < 16; ne++)
        for (int sf = 0; sf < 5; sf++)
          for (int rf = 0; rf < 6; rf++)
            step(W'(v), W'(ne), 4'b0000, sf, rf, 0, "sweep");

    // R6: no-port op issues while scheduler full
    step(4'b1111, 4'b0011, 4'b0000, 0, 8, 0, "R6 sched full");
    // R8: fence in slot 1 with ROB busy truncates group
    step(4'b1111, 4'b0000, 4'b0010, 8, 8, 0, "R8 fence truncate");
    // R9: held while rob not empty
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R9 hold a");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R9 hold b");
    // R10: not same cycle as empty
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 1, "R10 same cycle");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R10 resume");
    // R9: empty during fence issue cycle ignored
    step(4'b1111, 4'b0000, 4'b0001, 8, 8, 1, "R9 fence slot0");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R9 ignored empty");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 1, "R10 detect");
    step(4'b1111, 4'b0101, 4'b0000, 8, 8, 0, "R10 resume 2");
    // R8: fence blocked by full ROB does not start a wait
    step(4'b1111, 4'b0000, 4'b1000, 8, 3, 0, "R8 fence unfit");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R8 no wait");
    // R8: fence as last slot issues with exec ops
    step(4'b1111, 4'b0000, 4'b1000, 3, 8, 0, "R8 fence last");
    step(4'b1111, 4'b0000, 4'b0000, 8, 8, 0, "R9 hold c");
    // R1: reset clears pending wait
    @(negedge clk_i) rst_ni = 1'b0;
    m_wait = 0;
    @(negedge clk_i) rst_ni = 1'b1;
    step(4'b0111, 4'b0010, 4'b0000, 8, 8, 0, "R1 reset clears wait");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule